// File: doc/BRIEF.md
# Return-to-Zero FIR DAC Tap Generator

This block turns a one-bit sigma-delta modulator stream into the switching pattern for a digital FIR reconstruction DAC. A master clock runs at four times the modulator sample rate. A strobe marks each new modulator bit. The block expands that bit into a fixed four-chip return-to-zero code, with one chip per master clock. The chips then pass through a chain of single-bit register stages. Every stage output is a tap that drives one equal-weight current or resistor element outside the chip.

Both codes start with a zero chip and end with a one chip. As a result, the chip line switches the same number of times in every sample, whatever the data. The sixteen equal taps span four samples of chips. This places a zero of the summed response at half the modulator sample rate.

When no strobe arrives at a sample boundary, the block sends the negative code, so the output keeps returning to zero. A strobe that arrives partway through a code restarts the code sequence on that strobe.

Top module: `rz_fir_tap_gen`

## Requirements
- R1: While rst_ni is low, and after it is released, all taps and chip_o are 0. chip_o stays 0 until the first sample_en_i strobe is sampled.
- R2: When sample_en_i is sampled high at a clock edge, chip_o shows chip 0 of the new code right after that edge. Chips 1, 2 and 3 follow on the next three edges.
- R3: sample_bit_i = 0 (modulator -1) gives the chips 0,0,0,1. sample_bit_i = 1 (modulator +1) gives the chips 0,1,1,1. Chips are sent in that order.
- R4: If four chips of a code have been sent and no strobe comes at the next edge, the block sends the -1 code 0,0,0,1.
- R5: A strobe sampled before a code is complete drops the rest of that code. chip 0 of the new code appears after that edge.
- R6: On every edge, taps_o[0] takes the previous value of chip_o, and taps_o[k] takes the previous value of taps_o[k-1] for k from 1 to 15.
- R7: Once samples arrive back to back, chip_o rises once inside every code and falls once at every code boundary, whatever the data.
- R8: Half-rate notch: in steady state the count of ones in taps_o is constant. The count is 8 for alternating +1/-1 input, 12 for constant +1 and 4 for constant -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master (chip) clock, four times the sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_en_i | input | 1 | Strobe: a new modulator bit is valid |
| sample_bit_i | input | 1 | Modulator bit, 1 = +1, 0 = -1 |
| taps_o | output | 16 | Registered FIR tap outputs, bit k = stage k |
| chip_o | output | 1 | Current return-to-zero chip |

## Verification
Four properties are checked on every cycle:
- the shift relation between chip_o and the taps,
- chip 0 being zero after each strobe,
- the second chip of each code following the data bit,
- the last chip being one after an uninterrupted code.

Some behaviour only the bench scenarios can show:
- the idle code when samples are missing,
- realignment on an early strobe,
- the exact toggle count over a run of mixed data,
- the constant tap ones-count for alternating, all-plus and all-minus input.

The bench also covers the quiet output before the first strobe, and clearing in the middle of a stream.

// File: rtl/rz_fir_pkg.sv
package rz_fir_pkg;
  localparam int unsigned CHIPS = 4;
  localparam int unsigned TAPS  = 16;

  // bit k = chip sent k-th after the strobe
  localparam logic [CHIPS-1:0] NEG_CODE = 4'b1000;
  localparam logic [CHIPS-1:0] POS_CODE = 4'b1110;

  function automatic logic [CHIPS-1:0] code_for(input logic bit_i);
    return bit_i ? POS_CODE : NEG_CODE;
  endfunction
endpackage

// File: rtl/rz_chip_encoder.sv
module rz_chip_encoder
  import rz_fir_pkg::*;
#(
  parameter int unsigned N_CHIPS = CHIPS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_en_i,
  input  logic sample_bit_i,
  output logic chip_o
);
  localparam int unsigned CNT_W = (N_CHIPS > 1) ? $clog2(N_CHIPS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_CHIPS - 1);

  logic                  run_q;
  logic [CNT_W-1:0]      cnt_q;  // index of the next chip to send
  logic [N_CHIPS-1:0]    code_q;
  logic [N_CHIPS-1:0]    code_new;
  logic                  chip_q;

  assign code_new = code_for(sample_bit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      code_q <= '0;
      chip_q <= 1'b0;
    end else if (sample_en_i) begin
      // strobe realigns the chip counter
      run_q  <= 1'b1;
      code_q <= code_new;
      chip_q <= code_new[0];
      cnt_q  <= CNT_W'(1);
    end else if (run_q) begin
      if (cnt_q == '0) begin
        // boundary without a sample: idle on the -1 code
        code_q <= NEG_CODE;
        chip_q <= NEG_CODE[0];
        cnt_q  <= CNT_W'(1);
      end else begin
        chip_q <= code_q[cnt_q];
        cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
      end
    end
  end

  assign chip_o = chip_q;
endmodule

// File: rtl/rz_tap_shifter.sv
module rz_tap_shifter #(
  parameter int unsigned N_TAPS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chip_i,
  output logic [N_TAPS-1:0] taps_o
);
  logic [N_TAPS-1:0] stage_q;

  for (genvar k = 0; k < N_TAPS; k++) begin : g_stage
    logic d;
    if (k == 0) begin : g_head
      assign d = chip_i;
    end else begin : g_body
      assign d = stage_q[k-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[k] <= 1'b0;
      else         stage_q[k] <= d;
    end
  end

  // taps come straight from flops
  assign taps_o = stage_q;
endmodule

// File: rtl/rz_fir_tap_gen.sv
module rz_fir_tap_gen
  import rz_fir_pkg::*;
#(
  parameter int unsigned N_CHIPS = CHIPS,
  parameter int unsigned N_TAPS  = TAPS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_en_i,
  input  logic              sample_bit_i,
  output logic [N_TAPS-1:0] taps_o,
  output logic              chip_o
);
  logic chip;

  rz_chip_encoder #(.N_CHIPS(N_CHIPS)) u_enc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sample_en_i  (sample_en_i),
    .sample_bit_i (sample_bit_i),
    .chip_o       (chip)
  );

  rz_tap_shifter #(.N_TAPS(N_TAPS)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .chip_i (chip),
    .taps_o (taps_o)
  );

  assign chip_o = chip;
endmodule

// File: rtl/rz_fir_tap_gen_chk.sv
module rz_fir_tap_gen_chk #(
  parameter int unsigned N_TAPS = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_en_i,
  input logic              sample_bit_i,
  input logic [N_TAPS-1:0] taps_o,
  input logic              chip_o
);
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (taps_o == '0 && !chip_o));

  assert_first_chip_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_en_i |=> !chip_o);

  assert_second_chip_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_en_i ##1 !sample_en_i |=> (chip_o == $past(sample_bit_i, 2)));

  assert_shift_chain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (taps_o[0] == $past(chip_o)) &&
             (taps_o[N_TAPS-1:1] == $past(taps_o[N_TAPS-2:0])));

  assert_last_chip_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_en_i ##1 (!sample_en_i)[*3] |=> chip_o);
endmodule

bind rz_fir_tap_gen rz_fir_tap_gen_chk #(.N_TAPS(N_TAPS)) u_chk (.*);

// File: tb/sim_rz_fir_tap_gen.sv
module sim_rz_fir_tap_gen;
  localparam int unsigned NT = 16;
  localparam logic [3:0] NEG = 4'b1000;  // chip k = bit k
  localparam logic [3:0] POS = 4'b1110;
  localparam int unsigned NV = 12;
  // {present, bit}
  localparam logic [1:0] VEC [NV] = '{2'b11, 2'b10, 2'b11, 2'b00, 2'b11, 2'b11,
                                      2'b10, 2'b00, 2'b00, 2'b11, 2'b10, 2'b10};

  logic clk_i = 1'b0, rst_ni = 1'b0, sample_en_i = 1'b0, sample_bit_i = 1'b0;
  logic [NT-1:0] taps_o;
  logic chip_o;

  int checks = 0, errors = 0, toggles = 0;
  logic [NT-1:0] exp_taps = '0;
  logic last_chip = 1'b0, prev_obs = 1'b0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  rz_fir_tap_gen u0 (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, step one edge, sample at next negedge
  task automatic step(input logic en, input logic b, input logic exp_c,
                      input string req, input int exp_pop);
    sample_en_i = en; sample_bit_i = b;
    @(posedge clk_i); @(negedge clk_i);
    exp_taps  = {exp_taps[NT-2:0], last_chip};
    last_chip = exp_c;
    if (chip_o != prev_obs) toggles++;
    prev_obs = chip_o;
    chk(chip_o == exp_c, req, int'(chip_o), int'(exp_c));
    chk(taps_o == exp_taps, "R6", int'(taps_o), int'(exp_taps));
    if (exp_pop >= 0) chk($countones(taps_o) == exp_pop, "R8", $countones(taps_o), exp_pop);
    sample_en_i = 1'b0;
  endtask

  task automatic send(input logic present, input logic b, input string req, input int pop);
    logic [3:0] code;
    code = (present && b) ? POS : NEG;
    for (int c = 0; c < 4; c++) step(c == 0 && present, b, code[c], req, pop);
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0; #2;
    chk(taps_o == '0, "R1", int'(taps_o), 0);
    chk(chip_o == 1'b0, "R1", int'(chip_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    exp_taps = '0; last_chip = 1'b0; prev_obs = 1'b0;
  endtask

  initial begin
    #3;
    chk(taps_o == '0 && chip_o == 1'b0, "R1", int'(taps_o), 0);
    @(negedge clk_i); @(negedge clk_i); rst_ni = 1'b1;
    // R1: silent until first strobe
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, "R1", -1);

    // table walk: R2, R3, R4 codes
    toggles = 0;
    for (int v = 0; v < NV; v++)
      send(VEC[v][1], VEC[v][0], VEC[v][1] ? "R3" : "R4", -1);
    // R7: one rise per code, one fall per boundary
    chk(toggles == 2 * NV - 1, "R7", toggles, 2 * NV - 1);

    // R5: early strobe after two chips of +1
    step(1'b1, 1'b1, 1'b0, "R5", -1);
    step(1'b0, 1'b0, 1'b1, "R5", -1);
    send(1'b1, 1'b0, "R5", -1);
    send(1'b1, 1'b1, "R2", -1);

    // R8: alternating, then constant codes
    for (int i = 0; i < 4; i++) send(1'b1, i[0], "R8", -1);
    for (int i = 0; i < 4; i++) send(1'b1, i[0], "R8", 8);
    for (int i = 0; i < 4; i++) send(1'b1, 1'b1, "R8", -1);
    for (int i = 0; i < 2; i++) send(1'b1, 1'b1, "R8", 12);
    for (int i = 0; i < 4; i++) send(1'b0, 1'b0, "R4", -1);
    for (int i = 0; i < 2; i++) send(1'b1, 1'b0, "R8", 4);

    // R1: reset mid-stream, then quiet without strobe
    do_reset();
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, "R1", 0);
    send(1'b1, 1'b1, "R2", -1);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule